// File: doc/BRIEF.md
# Indexed Saturating Widening Multiply-Subtract Unit

This unit is a vector arithmetic stage. It works on three vectors of `VLEN` bits: a first source, a second source and an accumulator. The accumulator is cut into wide signed lanes, each twice the narrow element width. For every wide lane the unit takes the narrow signed element in the upper half of the matching first-source lane. It multiplies that element by one narrow signed element of the second source. That second element is picked by an immediate index and stays at the same position in each 128-bit segment, so one value is shared by all lanes of a segment.

The product is doubled and clamped to the signed range of the wide lane. The clamped value is subtracted from the accumulator lane, and the difference is clamped again. A width select chooses between 16-bit elements feeding 32-bit lanes and 32-bit elements feeding 64-bit lanes. All lanes are computed in parallel.

A two-state controller handles the handshake. The states are `ST_IDLE` (no result is presented) and `ST_EMIT` (a result is presented for one cycle). There are two transitions. `GO` enters `ST_EMIT` from either state whenever `in_valid` is high. `DRAIN` enters `ST_IDLE` from either state whenever `in_valid` is low. The result vector and the saturation flag are loaded on the same edge that takes `GO`, and they hold their value until the next load.

Top module: `wmsub_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `sat_flag` and `result` to zero on the next clock edge.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: With `wsel`=0 (16-bit elements, 32-bit lanes), lane e uses `src_a[32e+31:32e+16]` and `acc[32e+31:32e]`. Its second operand is `src_b[128s+16i+15:128s+16i]`, where s = e/4 is the segment and i = `idx` (0..7).
- R4: With `wsel`=1 (32-bit elements, 64-bit lanes), lane e uses `src_a[64e+63:64e+32]` and `acc[64e+63:64e]`. Its second operand is `src_b[128s+32i+31:128s+32i]`, where s = e/2 and i = `idx[1:0]`. `idx[2]` has no effect in this mode.
- R5: The product of the two elements is doubled. When both elements are the most negative narrow value, the doubled product is clamped to the largest positive wide value.
- R6: The lane result is the accumulator minus the clamped doubled product, clamped to the wide signed range. For a 2N-bit lane that range is -2^(2N-1) to 2^(2N-1)-1.
- R7: `sat_flag` is high with a result exactly when at least one lane of the selected width clamped at either stage.
- R8: While `in_valid` is low, `result` and `sat_flag` keep their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture inputs and start an operation |
| wsel | input | 1 | Element width: 0 = 16-bit, 1 = 32-bit |
| idx | input | 3 | Second-source element index within each segment |
| src_a | input | VLEN | First source vector (upper narrow halves used) |
| src_b | input | VLEN | Second source vector (indexed element used) |
| acc | input | VLEN | Accumulator vector |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | VLEN | Saturated lane differences |
| sat_flag | output | 1 | Some lane clamped in the last operation |

## Verification
Both clamp stages can act on the same lane in the same operation. If the accumulator holds its most negative value and both elements are the most negative narrow value, the product clamp gives the largest positive value, and the subtraction then clamps to the negative limit. The bench drives this case in both widths. It also drives cases where only one stage clamps, and it compares every lane and the single flag against a behavioural model each cycle. Back-to-back valid pulses are interleaved with idle cycles that carry changing inputs, so that the load-and-hold path is exercised as well.

// File: rtl/wmsub_pkg.sv
package wmsub_pkg;

    typedef enum logic [0:0] {
        WIDTH_H = 1'b0,
        WIDTH_S = 1'b1
    } width_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctl_state_e;

    localparam int SEG_BITS = 128;

endpackage

// File: rtl/wmsub_lane.sv
module wmsub_lane #(
    parameter int NW = 16
) (
    input  logic signed [NW-1:0]   a_i,
    input  logic signed [NW-1:0]   b_i,
    input  logic signed [2*NW-1:0] acc_i,
    output logic signed [2*NW-1:0] res_o,
    output logic                   sat_o
);
    localparam int WW = 2 * NW;
    localparam logic [WW-1:0] POS_LIM = {1'b0, {(WW-1){1'b1}}};
    localparam logic [WW-1:0] NEG_LIM = {1'b1, {(WW-1){1'b0}}};

    logic signed [WW-1:0] prod;
    logic        [WW:0]   dbl;
    logic        [WW-1:0] psat;
    logic                 p_ovf;
    logic        [WW:0]   diff;
    logic                 d_ovf;

    always_comb begin
        prod  = WW'(a_i) * WW'(b_i);
        dbl   = {prod, 1'b0};
        p_ovf = dbl[WW] ^ dbl[WW-1];
        if (p_ovf) begin
            psat = dbl[WW] ? NEG_LIM : POS_LIM;
        end else begin
            psat = dbl[WW-1:0];
        end
        diff  = {acc_i[WW-1], acc_i} - {psat[WW-1], psat};
        d_ovf = diff[WW] ^ diff[WW-1];
        if (d_ovf) begin
            res_o = diff[WW] ? NEG_LIM : POS_LIM;
        end else begin
            res_o = diff[WW-1:0];
        end
        sat_o = p_ovf | d_ovf;
    end
endmodule

// File: rtl/wmsub_array.sv
module wmsub_array
    import wmsub_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int NW   = 16,
    parameter int IDXW = 3
) (
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic [VLEN-1:0] acc,
    input  logic [IDXW-1:0] idx,
    output logic [VLEN-1:0] res,
    output logic            sat
);
    localparam int WW    = 2 * NW;
    localparam int LPS   = SEG_BITS / WW;
    localparam int NSEG  = VLEN / SEG_BITS;
    localparam int LANES = NSEG * LPS;

    logic [LANES-1:0] lane_sat;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [NW-1:0] b_sel;
        assign b_sel = src_b[s*SEG_BITS + NW*int'(idx) +: NW];
        for (genvar l = 0; l < LPS; l++) begin : g_lane
            localparam int E = s * LPS + l;
            wmsub_lane #(.NW(NW)) u_lane (
                .a_i   (src_a[E*WW + NW +: NW]),
                .b_i   (b_sel),
                .acc_i (acc[E*WW +: WW]),
                .res_o (res[E*WW +: WW]),
                .sat_o (lane_sat[E])
            );
        end
    end

    assign sat = |lane_sat;
endmodule

// File: rtl/wmsub_unit.sv
module wmsub_unit
    import wmsub_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            wsel,
    input  logic [2:0]      idx,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic [VLEN-1:0] acc,
    output logic            out_valid,
    output logic [VLEN-1:0] result,
    output logic            sat_flag
);
    ctl_state_e      state_q, state_d;
    width_e          wmode;
    logic [VLEN-1:0] res_h, res_s, res_sel;
    logic            sat_h, sat_s, sat_sel;

    assign wmode = width_e'(wsel);

    wmsub_array #(.VLEN(VLEN), .NW(16), .IDXW(3)) u_arr_h (
        .src_a (src_a),
        .src_b (src_b),
        .acc   (acc),
        .idx   (idx),
        .res   (res_h),
        .sat   (sat_h)
    );

    wmsub_array #(.VLEN(VLEN), .NW(32), .IDXW(2)) u_arr_s (
        .src_a (src_a),
        .src_b (src_b),
        .acc   (acc),
        .idx   (idx[1:0]),
        .res   (res_s),
        .sat   (sat_s)
    );

    always_comb begin
        unique case (wmode)
            WIDTH_H: begin res_sel = res_h; sat_sel = sat_h; end
            WIDTH_S: begin res_sel = res_s; sat_sel = sat_s; end
            default: begin res_sel = res_h; sat_sel = sat_h; end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            sat_flag <= 1'b0;
        end else if (in_valid) begin
            result   <= res_sel;
            sat_flag <= sat_sel;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/wmsub_unit_chk.sv
module wmsub_unit_chk #(
    parameter int VLEN = 256
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            out_valid,
    input logic [VLEN-1:0] result,
    input logic            sat_flag
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !sat_flag && result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(sat_flag));
endmodule

bind wmsub_unit wmsub_unit_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/wmsub_unit_test.sv
`timescale 1ns/1ps
module wmsub_unit_test;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          wsel = 1'b0;
    logic [2:0]    idx = '0;
    logic [VL-1:0] src_a = '0, src_b = '0, acc = '0;
    logic          out_valid, sat_flag;
    logic [VL-1:0] result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit started = 0;
    string cur_req = "R1";

    logic          m_valid;
    logic [VL-1:0] m_res;
    logic          m_sat;
    string         m_req;

    always #4 clk = ~clk;

    wmsub_unit #(.VLEN(VL)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wsel(wsel), .idx(idx),
        .src_a(src_a), .src_b(src_b), .acc(acc),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    function automatic logic signed [127:0] sx(input logic [VL-1:0] v, input int lo, input int w);
        logic signed [127:0] t;
        for (int i = 0; i < 128; i++) t[i] = (i < w) ? v[lo+i] : v[lo+w-1];
        return t;
    endfunction

    function automatic void ref_op(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                   input logic [VL-1:0] c, input logic ws, input logic [2:0] ix,
                                   output logic [VL-1:0] r, output logic s);
        int nw, ww, lps, k;
        logic signed [127:0] x, y, z, p, d, mx, mn;
        nw  = ws ? 32 : 16;
        ww  = 2 * nw;
        lps = 128 / ww;
        k   = ws ? int'(ix[1:0]) : int'(ix);
        mx  = (128'sd1 <<< (ww - 1)) - 128'sd1;
        mn  = -(128'sd1 <<< (ww - 1));
        r = '0;
        s = 1'b0;
        for (int e = 0; e < VL / ww; e++) begin
            x = sx(a, e*ww + nw, nw);
            y = sx(b, (e / lps) * 128 + k * nw, nw);
            z = sx(c, e*ww, ww);
            p = 128'sd2 * x * y;
            if (p > mx) begin p = mx; s = 1'b1; end
            d = z - p;
            if (d > mx) begin d = mx; s = 1'b1; end
            if (d < mn) begin d = mn; s = 1'b1; end
            for (int i = 0; i < ww; i++) r[e*ww + i] = d[i];
        end
    endfunction

    always @(posedge clk) begin
        logic [VL-1:0] r;
        logic s;
        started <= 1'b1;
        if (rst) begin
            m_valid <= 1'b0;
            m_res   <= '0;
            m_sat   <= 1'b0;
            m_req   <= "R1";
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                ref_op(src_a, src_b, acc, wsel, idx, r, s);
                m_res <= r;
                m_sat <= s;
                m_req <= cur_req;
            end
        end
    end

    always @(negedge clk) begin
        string tag_v, tag_r, tag_s;
        if (started) begin
            tag_v = rst ? "R1" : "R2";
            tag_r = rst ? "R1" : (m_valid ? m_req : "R8");
            tag_s = rst ? "R1" : (m_valid ? "R7" : "R8");
            checks++;
            if (out_valid !== m_valid) begin
                failures++;
                $display("FAIL %s out_valid actual=%0b expected=%0b", tag_v, out_valid, m_valid);
            end
            checks++;
            if (result !== m_res) begin
                failures++;
                $display("FAIL %s result actual=%h expected=%h", tag_r, result, m_res);
            end
            checks++;
            if (sat_flag !== m_sat) begin
                failures++;
                $display("FAIL %s sat_flag actual=%0b expected=%0b", tag_s, sat_flag, m_sat);
            end
        end
    end

    task automatic run_op(input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [VL-1:0] c,
                          input logic ws, input logic [2:0] ix, input string req);
        @(negedge clk);
        src_a = a; src_b = b; acc = c; wsel = ws; idx = ix; cur_req = req;
        in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = {8{$urandom}}; src_b = {8{$urandom}}; acc = {8{$urandom}};
            wsel = ~wsel; idx = idx + 3'd1;
        end
    endtask

    function automatic logic [VL-1:0] rnd();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [VL-1:0] small_vals();
        return rnd() & {16{16'h00FF}};
    endfunction

    initial begin
        logic [VL-1:0] a, b, c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3: 16-bit elements, several indices, distinct segments
        for (int i = 0; i < 8; i += 3) begin
            run_op(rnd(), rnd(), rnd(), 1'b0, 3'(i), "R3");
        end
        run_op(rnd(), rnd(), rnd(), 1'b0, 3'd7, "R3");
        idle(2);
        // R4: 32-bit elements, idx[2] must not matter
        a = rnd(); b = rnd(); c = rnd();
        run_op(a, b, c, 1'b1, 3'd3, "R4");
        run_op(a, b, c, 1'b1, 3'd7, "R4");
        run_op(rnd(), rnd(), rnd(), 1'b1, 3'd0, "R4");
        run_op(rnd(), rnd(), rnd(), 1'b1, 3'd5, "R4");
        idle(3);
        // R5: both elements most negative, product clamp
        run_op({16{16'h8000}}, {16{16'h8000}}, '0, 1'b0, 3'd2, "R5");
        run_op({8{32'h8000_0000}}, {8{32'h8000_0000}}, '0, 1'b1, 3'd1, "R5");
        // R5/R6: both stages clamp in one lane
        run_op({16{16'h8000}}, {16{16'h8000}}, {8{32'h8000_0000}}, 1'b0, 3'd4, "R6");
        run_op({8{32'h8000_0000}}, {8{32'h8000_0000}}, {4{64'h8000_0000_0000_0000}}, 1'b1, 3'd2, "R6");
        // R6: positive-side clamp of the difference
        run_op({16{16'h7FFF}}, {16{16'h8000}}, {8{32'h7FFF_FFFF}}, 1'b0, 3'd6, "R6");
        run_op({8{32'h7FFF_FFFF}}, {8{32'h8000_0000}}, {4{64'h7FFF_FFFF_FFFF_FFFF}}, 1'b1, 3'd0, "R6");
        idle(1);
        // R7: no clamping at all, then clamping in one lane only
        run_op(small_vals(), small_vals(), small_vals(), 1'b0, 3'd1, "R7");
        run_op(small_vals(), small_vals(), small_vals(), 1'b1, 3'd3, "R7");
        a = small_vals(); a[255:240] = 16'h8000;
        b = small_vals(); b[128 +: 16] = 16'h8000;
        run_op(a, b, small_vals(), 1'b0, 3'd0, "R7");
        // R8: inputs wander without a valid pulse
        idle(5);
        for (int i = 0; i < 20; i++) run_op(rnd(), rnd(), rnd(), 1'($urandom), 3'($urandom), "R6");
        idle(2);
        // R1: reset in the middle of activity
        run_op(rnd(), rnd(), rnd(), 1'b0, 3'd5, "R3");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idle(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule